// File: doc/BRIEF.md
# Ping-Pong Transmit Endpoint Buffer

This block is the transmit-side packet store for one IN endpoint of a USB device controller. It holds two 64-byte buffers that take turns. While one buffer waits for the serial engine, the other one fills. Bytes arrive one per cycle on a single write port, which a DMA engine or the CPU can drive. The serial engine sees the oldest committed buffer as a packet with a valid flag and a length. It reads the bytes in order, then pulses a done strobe, and the buffer is released.

A packet is committed in one of two ways. In DMA mode the buffer commits itself when its 64th byte lands. A shorter packet, or any packet filled with DMA off, waits for the CPU to pulse a packet-enable strobe; the strobe commits whatever count the buffer holds, including zero. After every commit, filling moves to the other buffer. When both buffers are occupied, extra bytes are dropped and a sticky overflow flag records the loss.

The DMA request depends only on the DMA-enable bit and on free space in the buffer being filled. Every time a buffer is released, an endpoint status flag is set. The CPU clears it by a write-one-to-clear. It reaches the interrupt output only through its own enable bit, whatever the DMA setting.

Top module: `usb_in_pingpong`

## Requirements
- R1: After synchronous reset, tx_valid, irq_status, irq_out and overflow are 0, and buffer 0 is the first buffer filled and the first one presented for transmit.
- R2: dma_req is 1 exactly when dma_en is 1 and the buffer being filled is uncommitted and holds fewer than 64 bytes. It follows dma_en in the same cycle.
- R3: With dma_en at 1, the accepted write that brings the fill buffer to 64 bytes commits it. From the next cycle on, tx_valid is 1 and tx_len is 64.
- R4: After any commit, filling moves to the other buffer. If that buffer is free, dma_req is 1 again in the cycle after the commit, with no CPU action.
- R5: With dma_en at 0, a buffer never commits by itself, even at 64 bytes. A pkt_commit pulse commits it, and tx_len then equals the byte count.
- R6: A pkt_commit pulse while the fill buffer holds zero bytes commits a packet with tx_len 0.
- R7: Committed packets are offered in commit order. tx_data shows byte 0 of the packet, and each tx_rd pulse moves to the next byte in write order. tx_valid and tx_len stay stable until tx_done.
- R8: tx_done while tx_valid is 1 frees the buffer and sets irq_status in the next cycle. int_clr clears irq_status, but a release in the same cycle wins and leaves it set.
- R9: irq_out equals irq_status AND int_en. dma_en has no effect on it.
- R10: While both buffers are committed, dma_req is 0. Writes are dropped without changing stored data, and any dropped write sets overflow, which stays 1 until reset.
- R11: Clearing dma_en drops dma_req in the same cycle. Bytes and packets already stored are kept.
- R12: A pkt_commit in the same cycle as an accepted write includes that byte in the committed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe (DMA or CPU) |
| wr_data | input | 8 | Byte to store |
| dma_en | input | 1 | DMA-mode enable bit |
| pkt_commit | input | 1 | CPU packet-enable strobe |
| int_en | input | 1 | Interrupt enable bit |
| int_clr | input | 1 | Write-one-to-clear for irq_status |
| dma_req | output | 1 | DMA transfer request |
| tx_valid | output | 1 | Oldest committed packet available |
| tx_len | output | 7 | Length of that packet, 0 to 64 |
| tx_data | output | 8 | Current byte of that packet |
| tx_rd | input | 1 | Advance to next byte |
| tx_done | input | 1 | Packet sent; free the buffer |
| irq_status | output | 1 | Endpoint status flag (buffer released) |
| irq_out | output | 1 | Masked interrupt to CPU |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
Commits, releases, flag updates and byte pointer moves are registered, so their effects appear on tx_valid, tx_len, tx_data, irq_status and overflow in the cycle after the strobe. dma_req and irq_out are combinational in dma_en and int_en, so they change in the same cycle as those inputs. The bench drives each input one time unit after a rising edge and samples one time unit after the next rising edge for registered results. For combinational results it samples one time unit after changing the input, with no clock in between. A driver pushes each accepted byte and each expected packet length into queues, and the drain routine pops them and compares them against the transmit port.

// File: rtl/inep_pkg.sv
package inep_pkg;

    localparam int DEF_DATA_W    = 8;
    localparam int DEF_PKT_BYTES = 64;
    localparam int NUM_BUF       = 2;

    // Source of a commit on the current fill buffer.
    typedef enum logic [1:0] {
        CMT_NONE = 2'd0,
        CMT_AUTO = 2'd1,
        CMT_CPU  = 2'd2
    } commit_kind_e;

    // Fate of a byte offered on the write port.
    typedef struct packed {
        logic accept;
        logic reject;
    } wr_result_t;

    function automatic logic flip_bank(input logic bank);
        return ~bank;
    endfunction

endpackage

// File: rtl/inep_fill_ctrl.sv
module inep_fill_ctrl
    import inep_pkg::*;
#(
    parameter int PKT_BYTES = DEF_PKT_BYTES,
    parameter int LEN_W     = $clog2(PKT_BYTES + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic                            dma_en,
    input  logic                            pkt_commit,
    input  logic                            tx_done,
    output logic                            fill_sel,
    output logic                            tx_sel,
    output logic [NUM_BUF-1:0]              committed,
    output logic [NUM_BUF-1:0][LEN_W-1:0]   count,
    output wr_result_t                      wr_res,
    output logic                            free_evt,
    output logic                            dma_req
);

    localparam logic [LEN_W-1:0] FULL_CNT = LEN_W'(PKT_BYTES);

    logic             fill_room;
    logic [LEN_W-1:0] next_cnt;
    commit_kind_e     commit_kind;

    always_comb begin
        fill_room     = !committed[fill_sel] && (count[fill_sel] < FULL_CNT);
        wr_res.accept = wr_en && fill_room;
        wr_res.reject = wr_en && !fill_room;
        next_cnt      = count[fill_sel] + LEN_W'(wr_res.accept);
        if (committed[fill_sel])
            commit_kind = CMT_NONE;
        else if (pkt_commit)
            commit_kind = CMT_CPU;
        else if (dma_en && wr_res.accept && (next_cnt == FULL_CNT))
            commit_kind = CMT_AUTO;
        else
            commit_kind = CMT_NONE;
        free_evt = tx_done && committed[tx_sel];
        dma_req  = dma_en && fill_room;
    end

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_bank_state
        always_ff @(posedge clk) begin
            if (rst) begin
                committed[b] <= 1'b0;
                count[b]     <= '0;
            end else if (free_evt && (tx_sel == 1'(b))) begin
                committed[b] <= 1'b0;
                count[b]     <= '0;
            end else if (fill_sel == 1'(b)) begin
                if (wr_res.accept)
                    count[b] <= next_cnt;
                if (commit_kind != CMT_NONE)
                    committed[b] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_sel <= 1'b0;
            tx_sel   <= 1'b0;
        end else begin
            if (commit_kind != CMT_NONE)
                fill_sel <= flip_bank(fill_sel);
            if (free_evt)
                tx_sel <= flip_bank(tx_sel);
        end
    end

endmodule

// File: rtl/inep_buf_mem.sv
module inep_buf_mem
    import inep_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int DEPTH  = DEF_PKT_BYTES,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_BUF-1:0][DATA_W-1:0] bank_q;

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_bank
        logic [DATA_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b)))
                store[wr_addr] <= wr_data;
        end

        assign bank_q[b] = store[rd_addr];
    end

    assign rd_data = bank_q[rd_bank];

endmodule

// File: rtl/inep_tx_port.sv
module inep_tx_port #(
    parameter int LEN_W  = 7,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic              tx_rd,
    input  logic              free_evt,
    output logic [ADDR_W-1:0] rd_addr
);

    logic [LEN_W-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (rst || free_evt)
            rd_ptr <= '0;
        else if (tx_rd && tx_valid && (rd_ptr < tx_len))
            rd_ptr <= rd_ptr + 1'b1;
    end

    assign rd_addr = rd_ptr[ADDR_W-1:0];

endmodule

// File: rtl/inep_flags.sv
module inep_flags (
    input  logic clk,
    input  logic rst,
    input  logic free_evt,
    input  logic wr_reject,
    input  logic int_clr,
    input  logic int_en,
    output logic irq_status,
    output logic irq_out,
    output logic overflow
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_status <= 1'b0;
            overflow   <= 1'b0;
        end else begin
            if (free_evt)
                irq_status <= 1'b1;
            else if (int_clr)
                irq_status <= 1'b0;
            if (wr_reject)
                overflow <= 1'b1;
        end
    end

    assign irq_out = irq_status && int_en;

endmodule

// File: rtl/usb_in_pingpong.sv
module usb_in_pingpong
    import inep_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int PKT_BYTES = DEF_PKT_BYTES
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic                               dma_en,
    input  logic                               pkt_commit,
    input  logic                               int_en,
    input  logic                               int_clr,
    output logic                               dma_req,
    output logic                               tx_valid,
    output logic [$clog2(PKT_BYTES+1)-1:0]     tx_len,
    output logic [DATA_W-1:0]                  tx_data,
    input  logic                               tx_rd,
    input  logic                               tx_done,
    output logic                               irq_status,
    output logic                               irq_out,
    output logic                               overflow
);

    localparam int LEN_W  = $clog2(PKT_BYTES + 1);
    localparam int ADDR_W = $clog2(PKT_BYTES);

    logic                          fill_sel;
    logic                          tx_sel;
    logic [NUM_BUF-1:0]            committed;
    logic [NUM_BUF-1:0][LEN_W-1:0] count;
    wr_result_t                    wr_res;
    logic                          free_evt;
    logic [ADDR_W-1:0]             rd_addr;

    inep_fill_ctrl #(
        .PKT_BYTES (PKT_BYTES),
        .LEN_W     (LEN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .dma_en     (dma_en),
        .pkt_commit (pkt_commit),
        .tx_done    (tx_done),
        .fill_sel   (fill_sel),
        .tx_sel     (tx_sel),
        .committed  (committed),
        .count      (count),
        .wr_res     (wr_res),
        .free_evt   (free_evt),
        .dma_req    (dma_req)
    );

    inep_buf_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (PKT_BYTES),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (wr_res.accept),
        .wr_bank (fill_sel),
        .wr_addr (count[fill_sel][ADDR_W-1:0]),
        .wr_data (wr_data),
        .rd_bank (tx_sel),
        .rd_addr (rd_addr),
        .rd_data (tx_data)
    );

    assign tx_valid = committed[tx_sel];
    assign tx_len   = count[tx_sel];

    inep_tx_port #(
        .LEN_W  (LEN_W),
        .ADDR_W (ADDR_W)
    ) u_txp (
        .clk      (clk),
        .rst      (rst),
        .tx_valid (tx_valid),
        .tx_len   (tx_len),
        .tx_rd    (tx_rd),
        .free_evt (free_evt),
        .rd_addr  (rd_addr)
    );

    inep_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .free_evt   (free_evt),
        .wr_reject  (wr_res.reject),
        .int_clr    (int_clr),
        .int_en     (int_en),
        .irq_status (irq_status),
        .irq_out    (irq_out),
        .overflow   (overflow)
    );

endmodule

// File: rtl/inep_checker.sv
module inep_checker #(
    parameter int PKT_BYTES = 64,
    parameter int LEN_W     = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             dma_en,
    input logic             dma_req,
    input logic             int_en,
    input logic             int_clr,
    input logic             irq_out,
    input logic             irq_status,
    input logic             tx_valid,
    input logic             tx_done,
    input logic [LEN_W-1:0] tx_len,
    input logic             overflow
);

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !dma_en |-> !dma_req); // R2

    AST_LEN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_len <= LEN_W'(PKT_BYTES))); // R3

    AST_PACKET_HELD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_done) |=> (tx_valid && $stable(tx_len))); // R7

    AST_STATUS_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_done) |=> irq_status); // R8

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq_status && !int_clr) |=> irq_status); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !int_en |-> !irq_out); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R10

endmodule

bind usb_in_pingpong inep_checker #(
    .PKT_BYTES (PKT_BYTES),
    .LEN_W     (LEN_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dma_en     (dma_en),
    .dma_req    (dma_req),
    .int_en     (int_en),
    .int_clr    (int_clr),
    .irq_out    (irq_out),
    .irq_status (irq_status),
    .tx_valid   (tx_valid),
    .tx_done    (tx_done),
    .tx_len     (tx_len),
    .overflow   (overflow)
);

// File: tb/sim_usb_in_pingpong.sv
module sim_usb_in_pingpong;

    localparam int CLK_PERIOD = 10;
    localparam int PKT        = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       dma_en = 1'b0;
    logic       pkt_commit = 1'b0;
    logic       int_en = 1'b0;
    logic       int_clr = 1'b0;
    logic       dma_req;
    logic       tx_valid;
    logic [6:0] tx_len;
    logic [7:0] tx_data;
    logic       tx_rd = 1'b0;
    logic       tx_done = 1'b0;
    logic       irq_status;
    logic       irq_out;
    logic       overflow;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] byte_q[$];
    int         len_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    usb_in_pingpong u0 (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .dma_en (dma_en), .pkt_commit (pkt_commit), .int_en (int_en),
        .int_clr (int_clr), .dma_req (dma_req), .tx_valid (tx_valid),
        .tx_len (tx_len), .tx_data (tx_data), .tx_rd (tx_rd),
        .tx_done (tx_done), .irq_status (irq_status), .irq_out (irq_out),
        .overflow (overflow)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Driver: one byte; accepted bytes go into the scoreboard queue.
    task automatic put_byte(input logic [7:0] d, input bit accepted);
        wr_en   = 1'b1;
        wr_data = d;
        tick();
        wr_en   = 1'b0;
        if (accepted) byte_q.push_back(d);
    endtask

    task automatic cpu_commit(input int exp_len);
        pkt_commit = 1'b1;
        tick();
        pkt_commit = 1'b0;
        len_q.push_back(exp_len);
    endtask

    // Monitor: pop expected packet and compare against the transmit port.
    task automatic drain(input bit clr_same_cycle);
        int exp_len;
        chk("R7", "tx_valid before drain", int'(tx_valid), 1);
        exp_len = len_q.pop_front();
        chk("R7", "tx_len", int'(tx_len), exp_len);
        for (int i = 0; i < exp_len; i++) begin
            chk("R7", "tx_data", int'(tx_data), int'(byte_q.pop_front()));
            tx_rd = 1'b1;
            tick();
            tx_rd = 1'b0;
        end
        tx_done = 1'b1;
        int_clr = clr_same_cycle;
        tick();
        tx_done = 1'b0;
        int_clr = 1'b0;
        chk("R8", "irq_status after release", int'(irq_status), 1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        chk("R1", "tx_valid", int'(tx_valid), 0);
        chk("R1", "irq_status", int'(irq_status), 0);
        chk("R1", "irq_out", int'(irq_out), 0);
        chk("R1", "overflow", int'(overflow), 0);
        chk("R2", "dma_req with dma_en=0", int'(dma_req), 0);
        dma_en = 1'b1;
        #1;
        chk("R2", "dma_req follows dma_en", int'(dma_req), 1);

        // R3/R4: DMA fill of buffer 0 auto-commits at 64
        for (int i = 0; i < PKT - 1; i++) put_byte(8'(i * 3 + 1), 1'b1);
        chk("R3", "no commit at 63", int'(tx_valid), 0);
        chk("R2", "dma_req at 63 bytes", int'(dma_req), 1);
        put_byte(8'((PKT - 1) * 3 + 1), 1'b1);
        len_q.push_back(PKT);
        chk("R3", "tx_valid after 64th", int'(tx_valid), 1);
        chk("R3", "tx_len after 64th", int'(tx_len), PKT);
        chk("R4", "dma_req reasserted on other buffer", int'(dma_req), 1);

        // R11: dropping dma_en drops request, keeps data
        dma_en = 1'b0;
        #1;
        chk("R11", "dma_req after dma_en cleared", int'(dma_req), 0);
        chk("R11", "packet kept", int'(tx_valid), 1);

        // R5: short packet in buffer 1 needs CPU commit
        for (int i = 0; i < 10; i++) put_byte(8'(8'hA0 + i), 1'b1);
        chk("R5", "oldest packet unchanged", int'(tx_len), PKT);
        cpu_commit(10);

        // R10: both committed
        dma_en = 1'b1;
        #1;
        chk("R10", "dma_req with both committed", int'(dma_req), 0);
        put_byte(8'h55, 1'b0);
        put_byte(8'h66, 1'b0);
        chk("R10", "overflow set", int'(overflow), 1);

        // R7/R8/R9: drain in commit order
        drain(1'b0);
        chk("R9", "irq_out masked", int'(irq_out), 0);
        chk("R7", "second packet len", int'(tx_len), 10);
        chk("R4", "dma_req after release", int'(dma_req), 1);
        int_en = 1'b1;
        #1;
        chk("R9", "irq_out enabled", int'(irq_out), 1);
        dma_en = 1'b0;
        #1;
        chk("R9", "irq_out unaffected by dma_en", int'(irq_out), 1);
        int_clr = 1'b1;
        tick();
        int_clr = 1'b0;
        chk("R8", "irq_status cleared", int'(irq_status), 0);
        chk("R9", "irq_out follows clear", int'(irq_out), 0);
        drain(1'b1);
        chk("R8", "release wins over clear", int'(irq_status), 1);
        chk("R10", "overflow sticky", int'(overflow), 1);
        chk("R7", "nothing pending", int'(tx_valid), 0);

        // R6: zero-length commit
        cpu_commit(0);
        chk("R6", "zero-length valid", int'(tx_valid), 1);
        chk("R6", "zero-length len", int'(tx_len), 0);
        drain(1'b0);

        // R12: commit together with a write
        put_byte(8'h11, 1'b1);
        put_byte(8'h22, 1'b1);
        wr_en = 1'b1;
        wr_data = 8'h33;
        pkt_commit = 1'b1;
        tick();
        wr_en = 1'b0;
        pkt_commit = 1'b0;
        byte_q.push_back(8'h33);
        len_q.push_back(3);
        chk("R12", "len includes same-cycle byte", int'(tx_len), 3);
        drain(1'b0);

        // R5: 64 bytes with DMA off, no self-commit
        for (int i = 0; i < PKT; i++) put_byte(8'(255 - i), 1'b1);
        chk("R5", "no auto-commit with dma_en=0", int'(tx_valid), 0);
        put_byte(8'h77, 1'b0);
        dma_en = 1'b1;
        #1;
        chk("R2", "no request when fill buffer full", int'(dma_req), 0);
        dma_en = 1'b0;
        cpu_commit(PKT);
        chk("R5", "CPU commit of full buffer", int'(tx_len), PKT);
        drain(1'b0);
        chk("R7", "scoreboard empty", byte_q.size(), 0);

        finish_run();
    end

endmodule